// File: doc/BRIEF.md
# Immediate and Variable Shift-Rotate Unit

A purely combinational 32-bit shift and rotate execution unit for the integer datapath of a 32-bit RISC pipeline. It receives decoded fields of a register-format instruction (the 6-bit function code, the 5-bit shift-amount field and one mode bit), together with the two register operands. It returns the shifted or rotated value of the `rt` operand and a flag that marks function codes that do not belong to the shift group.

Each of four operations exists in two forms. Left logical, right logical, right arithmetic and right rotate can take their amount from the instruction's shift-amount field (immediate form) or from the low five bits of the `rs` operand (variable form). Rotate has no function code of its own. It reuses the right-logical codes and is picked by one instruction bit. In the immediate form that bit is instruction bit 21, which comes in on its own port. In the variable form it is instruction bit 6, which is bit 0 of the shift-amount field. That field carries no amount in the variable form.

Top module: `shift_rotate_unit`

## Requirements
- R1: Function code 0 drives `rt_data` shifted left by `op_sa`, with zeros entering at bit 0.
- R2: Function code 2 with `imm_rot_sel` = 0 drives `rt_data` shifted right by `op_sa`, with zeros entering at bit 31.
- R3: Function code 2 with `imm_rot_sel` = 1 drives `rt_data` rotated right by `op_sa`: bits leaving at bit 0 re-enter at bit 31.
- R4: Function code 3 drives `rt_data` shifted right by `op_sa`, with copies of `rt_data[31]` entering at bit 31.
- R5: Function code 4 drives `rt_data` shifted left by `rs_data[4:0]`; `rs_data[31:5]` has no effect.
- R6: Function code 6 drives `rt_data` shifted right logically by `rs_data[4:0]` when `op_sa[0]` = 0, and rotated right by `rs_data[4:0]` when `op_sa[0]` = 1.
- R7: Function code 7 drives `rt_data` shifted right arithmetically by `rs_data[4:0]`.
- R8: For every legal shift or rotate, an effective amount of 0 returns `rt_data` unchanged.
- R9: Function codes 1, 5 and 8 to 63 drive `illegal_op` = 1 and `result` = 0. Codes 0, 2, 3, 4, 6 and 7 drive `illegal_op` = 0.
- R10: A mode bit that does not belong to the decoded form has no effect. `imm_rot_sel` is ignored for codes other than 2. In the immediate forms `op_sa[0]` acts only as the amount LSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_func | input | 6 | Function code of the instruction (bits 5:0) |
| op_sa | input | 5 | Shift-amount field (instruction bits 10:6); bit 0 is the variable-form rotate select |
| imm_rot_sel | input | 1 | Instruction bit 21; selects rotate in the immediate right-logical form |
| rt_data | input | 32 | Operand to be shifted or rotated |
| rs_data | input | 32 | Register operand; bits 4:0 give the variable-form amount |
| result | output | 32 | Shifted or rotated value, zero for an illegal code |
| illegal_op | output | 1 | High when the function code is outside the shift group |

## Verification
The bench sweeps all 64 function codes with both mode-bit values at amounts 0, 1, 31 and a random amount, then adds random operands. A rotate that builds its left term with a 32-position shift would give a wrong or zero result at amount 0. A rotate that drops the wrapped bits would match a plain logical shift and fail only when the operand has nonzero low bits. Dedicated cases swap the two mode bits between forms: a decoder that reads bit 21 in the variable form, or bit 6 in the immediate form, would rotate when it should shift or would take the wrong amount. Operands with bit 31 set separate arithmetic fill from logical fill. Random upper bits of `rs` expose a variable amount wider than five bits.

// File: rtl/sru_pkg.sv
// Package: shared encodings for the shift-rotate unit.
// Assumes the unit sees the 6-bit function code of a register-format
// instruction; the codes below are fixed by the instruction encoding.
package sru_pkg;

    localparam logic [5:0] FN_SLL_IMM = 6'd0;
    localparam logic [5:0] FN_SRL_IMM = 6'd2;
    localparam logic [5:0] FN_SRA_IMM = 6'd3;
    localparam logic [5:0] FN_SLL_VAR = 6'd4;
    localparam logic [5:0] FN_SRL_VAR = 6'd6;
    localparam logic [5:0] FN_SRA_VAR = 6'd7;

    // Operation performed by the shift core.
    typedef enum logic [1:0] {
        K_LEFT   = 2'd0,
        K_LRIGHT = 2'd1,
        K_ARIGHT = 2'd2,
        K_ROTR   = 2'd3
    } shift_kind_e;

endpackage

// File: rtl/sru_decode.sv
// Module: sru_decode
// Turns the function code and the two rotate-select bits into an operation
// kind, an amount-source select and an illegal flag.
// Assumes var_rot_bit is instruction bit 6 and imm_rot_bit is bit 21.
module sru_decode
    import sru_pkg::*;
(
    input  logic [5:0]  func,
    input  logic        imm_rot_bit,
    input  logic        var_rot_bit,
    output shift_kind_e kind,
    output logic        use_reg_amt,
    output logic        bad_code
);

    // Decode the function code into kind, amount source and legality.
    always_comb begin
        kind        = K_LEFT;
        use_reg_amt = 1'b0;
        bad_code    = 1'b0;
        unique case (func)
            FN_SLL_IMM: kind = K_LEFT;
            FN_SRL_IMM: kind = imm_rot_bit ? K_ROTR : K_LRIGHT;
            FN_SRA_IMM: kind = K_ARIGHT;
            FN_SLL_VAR: begin
                kind        = K_LEFT;
                use_reg_amt = 1'b1;
            end
            FN_SRL_VAR: begin
                kind        = var_rot_bit ? K_ROTR : K_LRIGHT;
                use_reg_amt = 1'b1;
            end
            FN_SRA_VAR: begin
                kind        = K_ARIGHT;
                use_reg_amt = 1'b1;
            end
            default:    bad_code = 1'b1;
        endcase
    end

endmodule

// File: rtl/sru_amount_sel.sv
// Module: sru_amount_sel
// Picks the shift amount from the instruction field or from the low bits
// of the register operand. Assumes DATA_W is a power of two.
module sru_amount_sel #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned AMT_W = $clog2(DATA_W)
) (
    input  logic [AMT_W-1:0]  imm_amt,
    input  logic [DATA_W-1:0] reg_val,
    input  logic              use_reg,
    output logic [AMT_W-1:0]  amt
);

    logic unused_reg_hi;

    // Upper operand bits never affect the amount.
    assign unused_reg_hi = ^reg_val[DATA_W-1:AMT_W];

    // Select the amount source.
    always_comb begin
        amt = use_reg ? reg_val[AMT_W-1:0] : imm_amt;
    end

endmodule

// File: rtl/sru_shift_core.sv
// Module: sru_shift_core
// Logarithmic shifter for left, logical right, arithmetic right and rotate
// right. Left shifts reuse the right-shift stages through bit reversal.
// ROT_IMPL picks the rotate structure: 0 folds rotation into the stages,
// 1 builds it as the OR of a left and a right shift, guarding amount 0.
// Assumes DATA_W is a power of two.
module sru_shift_core
    import sru_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ROT_IMPL = 0,
    localparam int unsigned AMT_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    input  shift_kind_e       kind,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] stg [0:AMT_W];
    logic [DATA_W-1:0] din_rev;
    logic [DATA_W-1:0] stg_rev;
    logic [DATA_W-1:0] barrel_out;
    logic              fill;
    logic              is_left;
    logic              stage_rot;

    // Operation flags seen by every stage.
    always_comb begin
        is_left = (kind == K_LEFT);
        fill    = (kind == K_ARIGHT) ? din[DATA_W-1] : 1'b0;
    end

    // Bit reversal for input and output of a left shift.
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign din_rev[i] = din[DATA_W-1-i];
        assign stg_rev[i] = stg[AMT_W][DATA_W-1-i];
    end

    // Stage 0 input: the operand, reversed for a left shift.
    always_comb begin
        stg[0] = is_left ? din_rev : din;
    end

    // One stage per amount bit, each moving by a power of two.
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int unsigned S = 1 << k;
        always_comb begin
            if (!amt[k]) begin
                stg[k+1] = stg[k];
            end else if (stage_rot) begin
                stg[k+1] = {stg[k][S-1:0], stg[k][DATA_W-1:S]};
            end else begin
                stg[k+1] = {{S{fill}}, stg[k][DATA_W-1:S]};
            end
        end
    end

    // Undo the reversal for a left shift.
    always_comb begin
        barrel_out = is_left ? stg_rev : stg[AMT_W];
    end

    if (ROT_IMPL == 0) begin : g_rot_staged
        // Rotation carried by the stages themselves.
        assign stage_rot = (kind == K_ROTR);
        assign dout      = barrel_out;
    end else begin : g_rot_or
        logic [AMT_W:0]    comp_amt;
        logic [DATA_W-1:0] rot_val;

        assign stage_rot = 1'b0;

        // Two-term rotate; amount 0 bypasses the full-width left term.
        always_comb begin
            comp_amt = (AMT_W+1)'(DATA_W) - {1'b0, amt};
            if (amt == '0) begin
                rot_val = din;
            end else begin
                rot_val = (din << comp_amt) | (din >> amt);
            end
        end

        // Final select between rotate and plain shift.
        assign dout = (kind == K_ROTR) ? rot_val : barrel_out;
    end

endmodule

// File: rtl/shift_rotate_unit.sv
// Module: shift_rotate_unit (top)
// Combinational shift/rotate execution unit. Decodes the function code,
// selects the amount and forces a zero result on an illegal code.
// Assumes op_sa is instruction bits 10:6 and imm_rot_sel is bit 21.
module shift_rotate_unit
    import sru_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ROT_IMPL = 0,
    localparam int unsigned AMT_W   = $clog2(DATA_W)
) (
    input  logic [5:0]        op_func,
    input  logic [AMT_W-1:0]  op_sa,
    input  logic              imm_rot_sel,
    input  logic [DATA_W-1:0] rt_data,
    input  logic [DATA_W-1:0] rs_data,
    output logic [DATA_W-1:0] result,
    output logic              illegal_op
);

    shift_kind_e       kind;
    logic              use_reg_amt;
    logic              bad_code;
    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] core_out;

    sru_decode u_dec (
        .func        (op_func),
        .imm_rot_bit (imm_rot_sel),
        .var_rot_bit (op_sa[0]),
        .kind        (kind),
        .use_reg_amt (use_reg_amt),
        .bad_code    (bad_code)
    );

    sru_amount_sel #(.DATA_W(DATA_W)) u_amt (
        .imm_amt (op_sa),
        .reg_val (rs_data),
        .use_reg (use_reg_amt),
        .amt     (amt)
    );

    sru_shift_core #(.DATA_W(DATA_W), .ROT_IMPL(ROT_IMPL)) u_core (
        .din  (rt_data),
        .amt  (amt),
        .kind (kind),
        .dout (core_out)
    );

    // Zero the result for codes outside the shift group.
    always_comb begin
        illegal_op = bad_code;
        result     = bad_code ? '0 : core_out;
    end

endmodule

// File: rtl/shift_rotate_unit_chk.sv
// Module: shift_rotate_unit_chk
// Immediate assertions on the port relations of shift_rotate_unit,
// evaluated whenever the inputs are fully known. Bound to the top below.
module shift_rotate_unit_chk #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned AMT_W = $clog2(DATA_W)
) (
    input logic [5:0]        op_func,
    input logic [AMT_W-1:0]  op_sa,
    input logic              imm_rot_sel,
    input logic [DATA_W-1:0] rt_data,
    input logic [DATA_W-1:0] rs_data,
    input logic [DATA_W-1:0] result,
    input logic              illegal_op
);

    logic             known;
    logic             legal;
    logic [AMT_W-1:0] eff_amt;
    logic             is_rot;

    // Classify the inputs independently of the decoder.
    always_comb begin
        known   = !$isunknown({op_func, op_sa, imm_rot_sel, rt_data, rs_data});
        legal   = (op_func < 6'd8) && (op_func != 6'd1) && (op_func != 6'd5);
        eff_amt = op_func[2] ? rs_data[AMT_W-1:0] : op_sa;
        is_rot  = ((op_func == 6'd2) && imm_rot_sel) ||
                  ((op_func == 6'd6) && op_sa[0]);
    end

    // Relational checks on the outputs.
    always_comb begin
        if (known) begin
            a_r9_illegal_zero: assert (illegal_op == !legal && (legal || result == '0))
                else $error("R9 illegal flag or zero result wrong");
            a_r8_zero_amount: assert (!(legal && eff_amt == '0) || result == rt_data)
                else $error("R8 zero amount changed operand");
            a_r3_rotate_keeps_ones: assert (!is_rot || $countones(result) == $countones(rt_data))
                else $error("R3/R6 rotate lost or gained bits");
            a_r4_sign_fill: assert (!(op_func == 6'd3 || op_func == 6'd7) ||
                                    result[DATA_W-1] == rt_data[DATA_W-1])
                else $error("R4/R7 sign bit not preserved");
            a_r1_low_zero: assert (!((op_func == 6'd0 || op_func == 6'd4) && eff_amt != '0) ||
                                   result[0] == 1'b0)
                else $error("R1/R5 left shift did not fill zero");
            a_r2_high_zero: assert (!(((op_func == 6'd2) || (op_func == 6'd6)) && !is_rot &&
                                      eff_amt != '0) || result[DATA_W-1] == 1'b0)
                else $error("R2/R6 logical right did not fill zero");
        end
    end

endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .op_func     (op_func),
    .op_sa       (op_sa),
    .imm_rot_sel (imm_rot_sel),
    .rt_data     (rt_data),
    .rs_data     (rs_data),
    .result      (result),
    .illegal_op  (illegal_op)
);

// File: tb/shift_rotate_unit_test.sv
// Bench for shift_rotate_unit: directed sweep of every function code and
// mode bit at corner amounts, then seeded random operands.
module shift_rotate_unit_test;

    logic        clk;
    logic        rst_n;
    logic [5:0]  op_func;
    logic [4:0]  op_sa;
    logic        imm_rot_sel;
    logic [31:0] rt_data;
    logic [31:0] rs_data;
    logic [31:0] result;
    logic        illegal_op;

    int total;
    int bad;
    bit done;

    shift_rotate_unit uut (
        .op_func     (op_func),
        .op_sa       (op_sa),
        .imm_rot_sel (imm_rot_sel),
        .rt_data     (rt_data),
        .rs_data     (rs_data),
        .result      (result),
        .illegal_op  (illegal_op)
    );

    // 100 MHz clock.
    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Reference: legality of a function code (R9).
    function automatic bit ref_legal(input logic [5:0] f);
        return (f == 6'd0) || (f == 6'd2) || (f == 6'd3) ||
               (f == 6'd4) || (f == 6'd6) || (f == 6'd7);
    endfunction

    // Reference result computed from the requirements.
    function automatic logic [31:0] ref_result(input logic [5:0] f, input logic [4:0] sa,
                                               input logic r21, input logic [31:0] rt,
                                               input logic [31:0] rs);
        logic [4:0] a;
        logic       rot;
        a = f[2] ? rs[4:0] : sa;
        if (!ref_legal(f)) return 32'd0;
        case (f)
            6'd0, 6'd4: return rt << a;
            6'd3, 6'd7: return 32'($signed(rt) >>> a);
            default: begin
                rot = (f == 6'd2) ? r21 : sa[0];
                if (!rot) return rt >> a;
                if (a == 5'd0) return rt;
                return (rt << (6'd32 - {1'b0, a})) | (rt >> a);
            end
        endcase
    endfunction

    // Requirement tag for a stimulus.
    function automatic string req_tag(input logic [5:0] f, input logic [4:0] sa,
                                      input logic r21, input logic [31:0] rs);
        logic [4:0] a;
        a = f[2] ? rs[4:0] : sa;
        if (!ref_legal(f)) return "R9";
        if (a == 5'd0) return "R8";
        case (f)
            6'd0: return "R1";
            6'd2: return r21 ? "R3" : "R2";
            6'd3: return "R4";
            6'd4: return "R5";
            6'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Apply one stimulus away from the clock edge and compare.
    task automatic apply_check(input logic [5:0] f, input logic [4:0] sa, input logic r21,
                               input logic [31:0] rt, input logic [31:0] rs,
                               input string tag);
        logic [31:0] exp_r;
        logic        exp_i;
        @(negedge clk);
        op_func = f; op_sa = sa; imm_rot_sel = r21; rt_data = rt; rs_data = rs;
        #2;
        exp_r = ref_result(f, sa, r21, rt, rs);
        exp_i = !ref_legal(f);
        total++;
        if (result !== exp_r || illegal_op !== exp_i) begin
            bad++;
            $display("FAIL %s func=%0d sa=%0d r21=%0b rt=%h rs=%h: got %h/%0b exp %h/%0b",
                     tag, f, sa, r21, rt, rs, result, illegal_op, exp_r, exp_i);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired: got running exp finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Main stimulus.
    initial begin
        logic [4:0]  amts [4];
        logic [31:0] rt;
        logic [31:0] rs;
        logic [4:0]  sa;
        int unsigned seed;
        seed  = 32'd12345;
        void'($urandom(seed));
        total = 0; bad = 0; done = 0;
        rst_n = 1'b0;
        op_func = '0; op_sa = '0; imm_rot_sel = 1'b0; rt_data = '0; rs_data = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Reset-state style check: all-zero inputs give zero, legal (R1).
        apply_check(6'd0, 5'd0, 1'b0, 32'd0, 32'd0, "R1");

        // Directed sweep: every code, both mode bits, corner amounts.
        amts[0] = 5'd0; amts[1] = 5'd1; amts[2] = 5'd31;
        for (int f = 0; f < 64; f++) begin
            for (int r = 0; r < 2; r++) begin
                amts[3] = 5'($urandom_range(2, 30));
                for (int k = 0; k < 4; k++) begin
                    rt = $urandom();
                    if (k == 2) rt[31] = 1'b1;
                    rt[0] = 1'b1;
                    rs = {$urandom()} & 32'hFFFF_FFE0;
                    if (f[2]) begin
                        rs = rs | {27'd0, amts[k]};
                        sa = {5'($urandom()) & 5'h1E} | 5'(r);
                    end else begin
                        sa = amts[k];
                        rs = rs | {27'd0, 5'($urandom())};
                    end
                    apply_check(6'(f), sa, 1'(r), rt, rs,
                                req_tag(6'(f), sa, 1'(r), rs));
                end
            end
        end

        // R10: mode bit of the other form has no effect.
        apply_check(6'd4, 5'd1, 1'b1, 32'h8000_0001, 32'hFFFF_FFE4, "R10");
        apply_check(6'd7, 5'd0, 1'b1, 32'h8000_0000, 32'h0000_0004, "R10");
        apply_check(6'd2, 5'd3, 1'b0, 32'h0000_00FF, 32'h0000_0000, "R10");
        apply_check(6'd6, 5'd0, 1'b1, 32'h0000_00FF, 32'h0000_0004, "R10");
        apply_check(6'd0, 5'd4, 1'b1, 32'h0000_000F, 32'h0000_0001, "R10");
        // R3 rotate wraps low bits to the top.
        apply_check(6'd2, 5'd4, 1'b1, 32'h0000_000F, 32'h0, "R3");
        // R6 variable rotate by 31 with ignored upper rs bits.
        apply_check(6'd6, 5'd1, 1'b0, 32'h8000_0001, 32'hABCD_EF1F, "R6");

        // Random operands across the shift group and a few illegal codes.
        for (int n = 0; n < 2000; n++) begin
            logic [5:0] f;
            logic       r;
            f  = (n % 10 == 9) ? 6'($urandom()) : 6'($urandom_range(0, 7));
            r  = 1'($urandom());
            sa = 5'($urandom());
            rt = $urandom();
            rs = $urandom();
            apply_check(f, sa, r, rt, rs, req_tag(f, sa, r, rs));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule